// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host reach an external asynchronous static memory that has two chip selects (one active low, one active high), per-byte lane enables, a write strobe, an output strobe and a read error flag. The host offers one request at a time on a valid/ready channel that carries a word address, write data, a byte-lane mask and a read/write bit. The controller then steps through a fixed sequence of strobe phases, and every phase length is a whole number of clock cycles. Each length is computed at elaboration by rounding a nanosecond minimum up at the configured clock period.

A read keeps the address, both selects, the lane enables and the output strobe steady for the whole access window. It captures data and the error flag at the final edge of that window and hands them back with a one-cycle response pulse. It then holds the output strobe inactive for an output-release interval before the next request is taken. A write asserts the write strobe for the longer of two lengths: the plain pulse minimum, or the memory's output-off time plus the data setup time. The controller drives the data bus only once the memory is sure to have let go of it. It keeps the data one cycle past the end of the strobe. A request whose lane mask is all zeros is absorbed without touching the memory.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and right after it, reqReady is 1, both selects are inactive (memCe1N=1, memCe2=0), memWeN=1, memOeN=1, memByteN is all ones, memDoutEn=0 and respValid=0.
- R2: A read keeps address, selects, output strobe and lane enables steady for RD_CYC = ceil(max(tRC, tAA, tDOE) / Tclk) cycles and samples memDin at the last edge of that window. respValid is then high for exactly one cycle. Lanes whose mask bit is 0 read as zero (mask bit 0 is data bits 7:0, bit 1 is bits 15:8).
- R3: The write strobe stays low for WP_CYC = max(ceil(tPWE), ceil(tAW), ceil(tHZWE) + ceil(tSD)) cycles, and address and lane enables do not move while it is low.
- R4: memDoutEn rises no earlier than ceil(tHZWE) cycles after the write strobe falls. It is never high while memOeN is low, and it stays high with unchanged data in the cycle after the strobe rises.
- R5: After a read, memOeN stays high for TA_CYC = max(1, ceil(tHZOE)) cycles before the next request is accepted, so the bus is free for a following write.
- R6: reqReady is 0 from the accepting edge until the cycle ends: RD_CYC + TA_CYC cycles for a read, WP_CYC + WH_CYC cycles for a write, where WH_CYC = max(1, ceil(tWC) − WP_CYC). While reqReady is 1, no strobe is active.
- R7: A write changes only the lanes whose mask bit is 1 (memByteN is the inverted mask during the strobe).
- R8: A request with an all-zero mask is accepted with no strobe activity and reqReady stays 1. A zero-mask read returns respRdata=0 and respErr=0 with respValid in the next cycle. A zero-mask write changes no memory contents.
- R9: memErr is sampled at the same edge as read data and returned on respErr.
- R10: A write never raises respValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle, request taken this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | DATA_W/8 | Byte-lane mask, bit i covers bits 8i+7:8i |
| respValid | output | 1 | One-cycle read response strobe |
| respRdata | output | DATA_W | Read data, unselected lanes zero |
| respErr | output | 1 | Error flag captured with the data |
| memAddr | output | ADDR_W | Memory address |
| memCe1N | output | 1 | Active-low select |
| memCe2 | output | 1 | Active-high select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output strobe |
| memByteN | output | DATA_W/8 | Active-low lane enables |
| memDout | output | DATA_W | Data toward memory |
| memDoutEn | output | 1 | Drive enable for memDout |
| memDin | input | DATA_W | Data from memory |
| memErr | input | 1 | Memory's corrected-error flag |

## Verification
The memory model in the bench returns a garbage word and a set error flag unless the access has stayed steady long enough, measured to the sampling edge. A controller that samples one cycle early, or that restarts the window when the address moves, therefore returns wrong data. The model also counts bus contention. This covers data driven while the memory is still driving or has only just stopped (a missing output-release gap after a read, or a missing wait after the write strobe falls). It also covers write strobes that are too short, data that changes too late before the strobe rises, and address or lane changes in the middle of a pulse. Lane masking is checked with byte writes followed by byte reads, so a design that leaks unselected lanes or writes them shows up as a data mismatch. All-zero masks are checked for zero strobe activity. An injected error bit must come back on exactly the address it belongs to.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Strobes passed from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture the host request
    logic ceAct;   // selects active
    logic weAct;   // write strobe active
    logic oeAct;   // output strobe active
    logic beAct;   // lane enables follow the mask
    logic doutEn;  // drive write data
    logic sample;  // capture read data and error flag
    logic zeroRd;  // zero-mask read answered at once
  } ctlStrobe_t;

  // Nanoseconds to clock cycles, rounded up
  function automatic int cycOf(input int ns, input int clkPs);
    return (ns * 1000 + clkPs - 1) / clkPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int RD_CYC = 12,
  parameter int WP_CYC = 12,
  parameter int WH_CYC = 1,
  parameter int TA_CYC = 5,
  parameter int HZ_CYC = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             reqReady,
  output ctlStrobe_t       strb
);

  localparam int MAXC  = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(WH_CYC, TA_CYC));
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam int S_IDLE = 0;
  localparam int S_RD   = 1;
  localparam int S_WR   = 2;
  localparam int S_WH   = 3;
  localparam int S_TA   = 4;
  localparam int NS     = 5;

  logic [NS-1:0]    st, stNext;
  logic [CNT_W-1:0] cnt;
  logic             accept, zeroMask;
  logic             rdLast, wrLast, whLast, taLast;

  assign accept   = st[S_IDLE] && reqValid;
  assign zeroMask = (reqMask == '0);
  assign rdLast   = (cnt == CNT_W'(RD_CYC - 1));
  assign wrLast   = (cnt == CNT_W'(WP_CYC - 1));
  assign whLast   = (cnt == CNT_W'(WH_CYC - 1));
  assign taLast   = (cnt == CNT_W'(TA_CYC - 1));

  always_comb begin
    stNext = st;
    if (st[S_IDLE]) begin
      if (accept && !zeroMask) stNext = reqWrite ? NS'(1 << S_WR) : NS'(1 << S_RD);
    end else if (st[S_RD]) begin
      if (rdLast) stNext = NS'(1 << S_TA);
    end else if (st[S_WR]) begin
      if (wrLast) stNext = NS'(1 << S_WH);
    end else if (st[S_WH]) begin
      if (whLast) stNext = NS'(1 << S_IDLE);
    end else if (st[S_TA]) begin
      if (taLast) stNext = NS'(1 << S_IDLE);
    end else begin
      stNext = NS'(1 << S_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= NS'(1 << S_IDLE);
      cnt <= '0;
    end else begin
      st <= stNext;
      if (st[S_IDLE] || (stNext != st)) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
    end
  end

  assign reqReady    = st[S_IDLE];
  assign strb.load   = accept;
  assign strb.ceAct  = st[S_RD] | st[S_WR];
  assign strb.weAct  = st[S_WR];
  assign strb.oeAct  = st[S_RD];
  assign strb.beAct  = st[S_RD] | st[S_WR];
  assign strb.doutEn = (st[S_WR] && (cnt >= CNT_W'(HZ_CYC))) || st[S_WH];
  assign strb.sample = st[S_RD] && rdLast;
  assign strb.zeroRd = accept && zeroMask && !reqWrite;

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDin,
  input  logic              memErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memByteN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic              respErr
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ, laneBits;
  logic [LANES-1:0]  maskQ;
  logic              errQ, validQ;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneBits[i*8 +: 8] = {8{maskQ[i]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
      rdataQ <= '0;
      errQ   <= 1'b0;
      validQ <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        maskQ  <= reqMask;
      end
      if (strb.sample) begin
        rdataQ <= memDin & laneBits;
        errQ   <= memErr;
      end else if (strb.zeroRd) begin
        rdataQ <= '0;
        errQ   <= 1'b0;
      end
      validQ <= strb.sample | strb.zeroRd;
    end
  end

  assign memAddr   = addrQ;
  assign memDout   = wdataQ;
  assign memDoutEn = strb.doutEn;
  assign memCe1N   = !strb.ceAct;
  assign memCe2    = strb.ceAct;
  assign memWeN    = !strb.weAct;
  assign memOeN    = !strb.oeAct;
  assign memByteN  = strb.beAct ? ~maskQ : '1;
  assign respValid = validQ;
  assign respRdata = rdataQ;
  assign respErr   = errQ;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 4000,
  parameter int T_RC_NS   = 45,
  parameter int T_AA_NS   = 45,
  parameter int T_DOE_NS  = 22,
  parameter int T_WC_NS   = 45,
  parameter int T_PWE_NS  = 35,
  parameter int T_AW_NS   = 35,
  parameter int T_SD_NS   = 25,
  parameter int T_HZWE_NS = 18,
  parameter int T_HZOE_NS = 18
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqMask,
  output logic                  respValid,
  output logic [DATA_W-1:0]     respRdata,
  output logic                  respErr,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memCe1N,
  output logic                  memCe2,
  output logic                  memWeN,
  output logic                  memOeN,
  output logic [DATA_W/8-1:0]   memByteN,
  output logic [DATA_W-1:0]     memDout,
  output logic                  memDoutEn,
  input  logic [DATA_W-1:0]     memDin,
  input  logic                  memErr
);

  localparam int LANES  = DATA_W / 8;
  localparam int RD_CYC = maxOf(maxOf(cycOf(T_RC_NS, CLK_PS), cycOf(T_AA_NS, CLK_PS)),
                                cycOf(T_DOE_NS, CLK_PS));
  localparam int HZ_CYC = cycOf(T_HZWE_NS, CLK_PS);
  localparam int WP_CYC = maxOf(maxOf(cycOf(T_PWE_NS, CLK_PS), cycOf(T_AW_NS, CLK_PS)),
                                HZ_CYC + cycOf(T_SD_NS, CLK_PS));
  localparam int WH_CYC = maxOf(1, cycOf(T_WC_NS, CLK_PS) - WP_CYC);
  localparam int TA_CYC = maxOf(1, cycOf(T_HZOE_NS, CLK_PS));

  ctlStrobe_t strb;

  asram_fsm #(
    .LANES (LANES),
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC),
    .WH_CYC(WH_CYC),
    .TA_CYC(TA_CYC),
    .HZ_CYC(HZ_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .reqReady(reqReady),
    .strb    (strb)
  );

  asram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .memDin   (memDin),
    .memErr   (memErr),
    .memAddr  (memAddr),
    .memCe1N  (memCe1N),
    .memCe2   (memCe2),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memByteN (memByteN),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .respValid(respValid),
    .respRdata(respRdata),
    .respErr  (respErr)
  );

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int WP_CYC = 12,
  parameter int HZ_CYC = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [DATA_W/8-1:0] reqMask,
  input logic                respValid,
  input logic [ADDR_W-1:0]   memAddr,
  input logic                memCe1N,
  input logic                memWeN,
  input logic                memOeN,
  input logic [DATA_W/8-1:0] memByteN,
  input logic                memDoutEn
);

  localparam int CW = $clog2(WP_CYC + 2);

  // Cycles the write strobe has been low, saturating
  logic [CW-1:0] weLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            weLowCnt <= '0;
    else if (memWeN)                      weLowCnt <= '0;
    else if (weLowCnt != CW'(WP_CYC + 1)) weLowCnt <= weLowCnt + 1'b1;
  end

  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCe1N && memWeN && memOeN && !memDoutEn));

  // R3
  we_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memByteN)));

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWeN && $past(!memWeN)) |-> (weLowCnt == CW'(WP_CYC)));

  // R4
  dout_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEn && !memWeN) |-> (weLowCnt >= CW'(HZ_CYC)));

  // R4
  dout_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> memOeN);

  // R2
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqMask == '0)) |=> (reqReady && memCe1N));

endmodule

bind asram_ctrl asram_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WP_CYC(WP_CYC),
  .HZ_CYC(HZ_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqMask  (reqMask),
  .respValid(respValid),
  .memAddr  (memAddr),
  .memCe1N  (memCe1N),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memByteN (memByteN),
  .memDoutEn(memDoutEn)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NW = 1 << AW;
  localparam int HALF = 2;

  // Expected cycle counts, from the requirements at 4000 ps
  function automatic int cyc(input int ns);
    return (ns * 1000 + 3999) / 4000;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0] reqMask = '0;
  logic reqReady, respValid, respErr;
  logic [DW-1:0] respRdata;
  logic [AW-1:0] memAddr;
  logic memCe1N, memCe2, memWeN, memOeN, memDoutEn;
  logic [1:0] memByteN;
  logic [DW-1:0] memDout;
  logic [DW-1:0] memDin = 16'hBAD5;
  logic memErr = 1'b1;

  int checks = 0, fails = 0;
  int viol = 0;
  int lastPulse = 0, lastGap = 0;
  int lastBusy, lastResp, wrResp = 0;
  logic firstCe1N;
  logic [DW-1:0] gotData;
  logic gotErr;
  logic [DW-1:0] mdl [NW];
  logic errBits [NW];
  logic [DW-1:0] expMem [NW];

  always #2 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(4000)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .respValid(respValid), .respRdata(respRdata), .respErr(respErr),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN),
    .memOeN(memOeN), .memByteN(memByteN), .memDout(memDout), .memDoutEn(memDoutEn),
    .memDin(memDin), .memErr(memErr)
  );

  // ---------------- timing-checking memory model (evaluated mid-cycle)
  logic pWr = 0, pDrv = 0, pDen = 0;
  logic [AW-1:0] pAddr = '0;
  logic [1:0] pByteN = 2'b11;
  logic [DW-1:0] pDout = '0;
  longint tWs = 0, tDrvEnd = -1000, tData = 0, tRs = 0;

  always @(negedge clk) begin
    longint now;
    logic sel, wrAct, drv;
    now   = $time;
    sel   = !memCe1N && memCe2 && (memByteN != 2'b11);
    wrAct = sel && !memWeN;
    drv   = sel && !memOeN && memWeN;
    if (rstN) begin
      if (wrAct && !pWr) tWs = now;
      if (pDrv && !drv) tDrvEnd = now;
      if (memDoutEn && drv) viol++;
      if (memDoutEn && !pDen) begin
        if (now - tDrvEnd < 18) viol++;
        if (wrAct && (now - tWs < 18)) viol++;
        lastGap = int'(now - tWs);
      end
      if (memDoutEn && (!pDen || memDout != pDout)) tData = now;
      if (wrAct && pWr && (memAddr != pAddr || memByteN != pByteN)) viol++;
      if (pWr && !wrAct) begin
        lastPulse = int'(now - tWs);
        if (lastPulse < 43) viol++;
        if (now - tData < 25) viol++;
        if (!memDoutEn || memDout != pDout) viol++;
        if (!pByteN[0]) mdl[pAddr][7:0]  = pDout[7:0];
        if (!pByteN[1]) mdl[pAddr][15:8] = pDout[15:8];
      end
      if (drv && (!pDrv || memAddr != pAddr || memByteN != pByteN)) tRs = now;
      if (drv && (now + HALF - tRs >= 45)) begin
        memDin[7:0]  = memByteN[0] ? 8'hEE : mdl[memAddr][7:0];
        memDin[15:8] = memByteN[1] ? 8'hEE : mdl[memAddr][15:8];
        memErr       = errBits[memAddr];
      end else begin
        memDin = 16'hBAD5;
        memErr = 1'b1;
      end
    end
    pWr = wrAct; pDrv = drv; pDen = memDoutEn;
    pAddr = memAddr; pByteN = memByteN; pDout = memDout;
  end

  // ---------------- helpers
  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic doReq(input logic wr, input int a, input logic [DW-1:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(a); reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    firstCe1N = memCe1N;
    lastBusy = 0; lastResp = 0;
    forever begin
      if (respValid) begin lastResp++; gotData = respRdata; gotErr = respErr; end
      if (reqReady) break;
      lastBusy++;
      @(negedge clk);
    end
    if (wr) begin
      wrResp += lastResp;
      if (m[0]) expMem[a][7:0]  = d[7:0];
      if (m[1]) expMem[a][15:8] = d[15:8];
    end
  endtask

  task automatic readChk(input int a, input logic [1:0] m, input string tag);
    logic [DW-1:0] e;
    doReq(1'b0, a, '0, m);
    e = {m[1] ? expMem[a][15:8] : 8'h00, m[0] ? expMem[a][7:0] : 8'h00};
    check(lastResp == 1, {tag, " resp pulse"}, lastResp, 1);
    check(gotData == e, {tag, " data"}, gotData, e);
    check(gotErr == (errBits[a] && m != 0), {tag, " err"}, gotErr, errBits[a]);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- stimulus
  initial begin
    for (int i = 0; i < NW; i++) begin
      mdl[i] = '0; expMem[i] = '0; errBits[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady && memCe1N && !memCe2 && memWeN && memOeN, "R1 strobes in reset",
          {reqReady, memCe1N, memCe2, memWeN, memOeN}, 5'b11011);
    check(memByteN == 2'b11 && !memDoutEn && !respValid, "R1 lanes/drive in reset",
          {memByteN, memDoutEn, respValid}, 4'b1100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && memCe1N && memWeN && memOeN && !memDoutEn, "R1 after reset",
          {reqReady, memCe1N, memWeN, memOeN, memDoutEn}, 5'b11110);

    // R3 R4 R7: full writes to every word, R6 write busy length
    for (int a = 0; a < NW; a++) begin
      doReq(1'b1, a, pat(a), 2'b11);
      if (a == 0) begin
        check(lastBusy == mx(mx(cyc(35), cyc(35)), cyc(18) + cyc(25)) + mx(1, cyc(45) - 12),
              "R6 write busy", lastBusy, 13);
        check(lastPulse == 4 * mx(cyc(35), cyc(18) + cyc(25)), "R3 pulse ns", lastPulse, 48);
        check(lastGap >= 18 && lastGap == 4 * cyc(18), "R4 drive delay ns", lastGap, 20);
      end
    end

    // R2 full reads; R6 read busy; R5 release gap inside busy
    for (int a = 0; a < NW; a++) begin
      readChk(a, 2'b11, "R2 full read");
      if (a == 0)
        check(lastBusy == mx(mx(cyc(45), cyc(45)), cyc(22)) + mx(1, cyc(18)),
              "R6 R5 read busy", lastBusy, 17);
    end

    // R7 byte writes, then full read-back
    for (int a = 0; a < 4; a++) doReq(1'b1, a, 16'h3C00 | 16'(a), 2'b01);
    for (int a = 4; a < 8; a++) doReq(1'b1, a, 16'h00C3 | 16'(a << 8), 2'b10);
    for (int a = 0; a < 8; a++) readChk(a, 2'b11, "R7 lane write");

    // R2 byte reads
    readChk(8, 2'b01, "R2 low lane read");
    readChk(8, 2'b10, "R2 high lane read");
    readChk(5, 2'b01, "R2 low lane read b");

    // R8 zero mask write and read
    doReq(1'b1, 9, 16'hFFFF, 2'b00);
    check(lastBusy == 0 && firstCe1N, "R8 zero write idle", {lastBusy[3:0], firstCe1N}, 5'b00001);
    readChk(9, 2'b11, "R8 zero write no change");
    doReq(1'b0, 9, '0, 2'b00);
    check(lastBusy == 0 && lastResp == 1 && firstCe1N, "R8 zero read resp",
          {lastBusy[3:0], lastResp[1:0], firstCe1N}, 7'b0000011);
    check(gotData == '0 && !gotErr, "R8 zero read data", {gotErr, gotData}, 0);

    // R9 error flag per address
    errBits[3] = 1'b1;
    readChk(3, 2'b11, "R9 err set");
    readChk(4, 2'b11, "R9 err clear");
    errBits[3] = 1'b0;

    // Alternating write after read, read after write (R5 turnaround)
    for (int a = 10; a < NW; a++) begin
      doReq(1'b1, a, ~pat(a), 2'b11);
      readChk(a, 2'b11, "R5 write-read mix");
    end

    // R10 and timing summary
    check(wrResp == 0, "R10 write no resp", wrResp, 0);
    check(viol == 0, "R3 R4 R5 model timing", viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule